// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation ADC peripheral. Software writes a 1 to the GO control bit to request a conversion. The sequencer waits for the instruction-cycle phase strobe before it starts the conversion clock. In RC mode it waits one further instruction cycle, so that a sleep instruction can execute first. It then releases the sample/hold switch so the held voltage is isolated, and runs a fixed frame of twelve conversion-clock periods. During the ten middle periods it drives trial codes to an external DAC and resolves the result one bit at a time from an external comparator.

In the final period the result register takes the new code. On the same clock edge GO drops and a sticky completion flag rises, so software can read the result on the next instruction cycle. Clearing GO during a request or a conversion abandons it. The conversion clock comes either from the system clock divided by 2, 8 or 32, or from an external RC-oscillator enable strobe. The sample/hold, DAC and comparator are outside the block.

Top module: `sar_seq`

## Requirements
- R1: After reset, go and done_flag are 0, sample_en is 1, and result and dac_code are 0.
- R2: A cycle with go_wr_en=1 and go_wr_data=1 while go is 0 sets go on the next edge. The conversion starts on the edge at which q4_strobe is next seen high: sample_en drops on that edge and stays 0 until completion.
- R3: With clk_sel=3 (RC), the conversion starts on the second q4_strobe seen after the GO write instead of the first.
- R4: clk_sel selects the length of one conversion period: 0 gives 2 system clocks, 1 gives 8, 2 gives 32, and 3 gives one period per rc_tick pulse. The frame lasts exactly 12 periods, so sample_en is low for 24, 96 or 384 system clocks, or across exactly 12 rc_tick pulses in RC mode.
- R5: Period 0 is setup, with dac_code 0. Periods 1 to 10 try bits 9 down to 0, so the first trial code is 0x200. A trial bit is kept when cmp_ge is 1 (input at least the DAC level) and cleared otherwise. With an ideal comparator the result equals the input code.
- R6: On the completion edge, at the end of period 11, result takes the new code, go falls and done_flag is set, all on the same edge. Before that edge result keeps its previous value.
- R7: A GO write of 0 while go is 1 aborts the request or the conversion. On the next edge go is 0 and sample_en is 1, result keeps its old value and done_flag is not set.
- R8: done_flag stays set until a cycle with flag_clr=1. A completion in the same cycle as flag_clr wins.
- R9: A GO write of 1 while go is 1 is ignored. The running frame keeps its length and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q4_strobe | input | 1 | One-cycle pulse in the last phase of each instruction cycle |
| clk_sel | input | 2 | Conversion clock source: 0 /2, 1 /8, 2 /32, 3 RC enable |
| rc_tick | input | 1 | Conversion clock enable from the RC oscillator |
| go_wr_en | input | 1 | Software write strobe for the GO bit |
| go_wr_data | input | 1 | Value written to GO |
| flag_clr | input | 1 | Software clear of the completion flag |
| cmp_ge | input | 1 | Comparator: 1 when the held input is at least the DAC level |
| dac_code | output | 10 | Trial code driven to the DAC |
| sample_en | output | 1 | 1 = sampling, 0 = hold capacitor isolated |
| result | output | 10 | Conversion result register |
| go | output | 1 | GO status: 1 while a request or a conversion is pending |
| done_flag | output | 1 | Sticky completion interrupt flag |

## Verification
The bench feeds the comparator from a model input code. It uses alternating bit patterns (0x2AA, 0x155), both extremes (0x000, 0x3FF) and the values on either side of mid-scale (0x200, 0x1FF). Together these show up a wrong keep/clear rule, a wrong bit order and an off-by-one in the last bit. Each clock source is run once, and the measured hold window tells the three divide ratios and the RC enable apart. The q4 count before the start separates the normal start from the RC start. A repeated GO write in mid-frame and an abort run with a known old result show whether writes while busy leak into the frame, the flag or the result.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

  typedef enum logic [1:0] {
    SRC_DIV2  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_RC    = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARM     = 2'd1,
    ST_RC_HOLD = 2'd2,
    ST_CONV    = 2'd3
  } seq_state_e;

  // System clocks per conversion period for the divided sources
  function automatic int unsigned div_ratio(input clk_src_e src);
    case (src)
      SRC_DIV2: return 2;
      SRC_DIV8: return 8;
      default:  return 32;
    endcase
  endfunction

endpackage

// File: rtl/sar_tick_gen.sv
`timescale 1ns/1ps
module sar_tick_gen
  import sar_seq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  clk_src_e src,
  input  logic     rc_tick,
  output logic     tick
);

  logic [CNT_W-1:0] div_cnt;
  logic [CNT_W-1:0] div_last;
  logic             div_hit;
  logic             use_rc;

  assign use_rc   = (src == SRC_RC);
  assign div_last = CNT_W'(div_ratio(src) - 1);
  assign div_hit  = (div_cnt == div_last);

  // Divider restarts from zero every time the frame starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!run || use_rc || div_hit) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tick = run & (use_rc ? rc_tick : div_hit);

endmodule

// File: rtl/sar_frame_ctrl.sv
`timescale 1ns/1ps
module sar_frame_ctrl
  import sar_seq_pkg::*;
#(
  parameter int FRAME = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q4_strobe,
  input  logic             go_wr_en,
  input  logic             go_wr_data,
  input  logic [1:0]       clk_sel,
  input  logic             tick,
  input  logic             flag_clr,
  output seq_state_e       state,
  output clk_src_e         src_q,
  output logic [CNT_W-1:0] cnt,
  output logic             conv_start,
  output logic             done_pulse,
  output logic             abort_pulse,
  output logic             done_flag
);

  localparam logic [CNT_W-1:0] LAST_PERIOD = CNT_W'(FRAME - 1);

  seq_state_e state_nx;
  logic       start_req;
  logic       arm_ready;

  assign start_req   = (state == ST_IDLE) && go_wr_en && go_wr_data;
  assign abort_pulse = (state != ST_IDLE) && go_wr_en && !go_wr_data;
  assign arm_ready   = ((state == ST_ARM) && (src_q != SRC_RC)) || (state == ST_RC_HOLD);
  assign conv_start  = !abort_pulse && q4_strobe && arm_ready;
  assign done_pulse  = !abort_pulse && (state == ST_CONV) && tick && (cnt == LAST_PERIOD);

  always_comb begin
    state_nx = state;
    if (abort_pulse) begin
      state_nx = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:    if (start_req) state_nx = ST_ARM;
        ST_ARM:     if (q4_strobe) state_nx = (src_q == SRC_RC) ? ST_RC_HOLD : ST_CONV;
        ST_RC_HOLD: if (q4_strobe) state_nx = ST_CONV;
        ST_CONV:    if (done_pulse) state_nx = ST_IDLE;
        default:    state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      src_q <= SRC_DIV2;
    end else begin
      state <= state_nx;
      if (start_req) src_q <= clk_src_e'(clk_sel);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (conv_start) begin
      cnt <= '0;
    end else if ((state == ST_CONV) && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else if (done_pulse) begin
      done_flag <= 1'b1;
    end else if (flag_clr) begin
      done_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_search.sv
`timescale 1ns/1ps
module sar_search #(
  parameter int RES_W = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial,
  output logic             bit_tick
);

  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [CNT_W-1:0] RES_CNT = CNT_W'(RES_W);

  logic [CNT_W-1:0] idx_full;
  logic [IDX_W-1:0] bit_idx;
  logic             in_bits;

  // Settle the bit under test and raise the next lower one
  function automatic logic [RES_W-1:0] next_trial(
    input logic [RES_W-1:0] cur,
    input logic [IDX_W-1:0] idx,
    input logic             keep
  );
    logic [RES_W-1:0] nxt;
    nxt = cur;
    if (!keep) nxt[idx] = 1'b0;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
    return nxt;
  endfunction

  assign idx_full = RES_CNT - cnt;
  assign bit_idx  = idx_full[IDX_W-1:0];
  assign in_bits  = (cnt != '0) && (cnt <= RES_CNT);
  assign bit_tick = tick && in_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial <= '0;
    end else if (conv_start) begin
      trial <= '0;
    end else if (tick && (cnt == '0)) begin
      trial <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (bit_tick) begin
      trial <= next_trial(trial, bit_idx, cmp_ge);
    end
  end

endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int MAX_DIV = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q4_strobe,
  input  logic [1:0]       clk_sel,
  input  logic             rc_tick,
  input  logic             go_wr_en,
  input  logic             go_wr_data,
  input  logic             flag_clr,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_en,
  output logic [RES_W-1:0] result,
  output logic             go,
  output logic             done_flag
);

  localparam int FRAME = RES_W + 2;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int DIV_W = $clog2(MAX_DIV);

  seq_state_e       state;
  clk_src_e         src_q;
  logic [CNT_W-1:0] cnt;
  logic             conv_start;
  logic             done_pulse;
  logic             abort_pulse;
  logic             converting;
  logic             tick;
  logic             bit_tick;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] result_q;

  assign converting = (state == ST_CONV);

  sar_frame_ctrl #(.FRAME(FRAME), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .q4_strobe   (q4_strobe),
    .go_wr_en    (go_wr_en),
    .go_wr_data  (go_wr_data),
    .clk_sel     (clk_sel),
    .tick        (tick),
    .flag_clr    (flag_clr),
    .state       (state),
    .src_q       (src_q),
    .cnt         (cnt),
    .conv_start  (conv_start),
    .done_pulse  (done_pulse),
    .abort_pulse (abort_pulse),
    .done_flag   (done_flag)
  );

  sar_tick_gen #(.CNT_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (converting),
    .src     (src_q),
    .rc_tick (rc_tick),
    .tick    (tick)
  );

  sar_search #(.RES_W(RES_W), .CNT_W(CNT_W)) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .tick       (tick),
    .cnt        (cnt),
    .cmp_ge     (cmp_ge),
    .trial      (trial),
    .bit_tick   (bit_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (done_pulse) begin
      result_q <= trial;
    end
  end

  assign result    = result_q;
  assign dac_code  = trial;
  assign go        = (state != ST_IDLE);
  assign sample_en = !converting;

endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             sample_en,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] dac_code,
  input logic             done_flag,
  input logic             flag_clr,
  input logic             conv_start,
  input logic             tick,
  input logic             done_pulse,
  input logic             abort_pulse
);

  localparam int FRAME = RES_W + 2;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0] seen_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_ticks <= '0;
    end else if (conv_start) begin
      seen_ticks <= '0;
    end else if (tick && !sample_en) begin
      seen_ticks <= seen_ticks + 1'b1;
    end
  end

  // R4: hold only while a conversion is pending
  p_hold_needs_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |-> go);

  // R4: completion comes on the twelfth period boundary
  p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (seen_ticks == CNT_W'(FRAME - 1)));

  // R5: setup period drives a zero trial code
  p_setup_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (dac_code == '0));

  // R6: completion drops GO, raises the flag, restores sampling
  p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> (!go && done_flag && sample_en));

  // R6: result only changes on completion
  p_result_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $past(done_pulse));

  // R7: abort leaves the result alone and ends the request
  p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> (!go && sample_en && $stable(result)));

  // R8: flag is sticky
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .go          (go),
  .sample_en   (sample_en),
  .result      (result),
  .dac_code    (dac_code),
  .done_flag   (done_flag),
  .flag_clr    (flag_clr),
  .conv_start  (conv_start),
  .tick        (tick),
  .done_pulse  (done_pulse),
  .abort_pulse (abort_pulse)
);

// File: tb/tb_sar_seq.sv
`timescale 1ns/1ps
module tb_sar_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       q4_strobe = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       rc_tick = 1'b0;
  logic       go_wr_en = 1'b0;
  logic       go_wr_data = 1'b0;
  logic       flag_clr = 1'b0;
  logic       cmp_ge;
  logic [9:0] dac_code;
  logic       sample_en;
  logic [9:0] result;
  logic       go;
  logic       done_flag;

  logic [9:0] vin = 10'd0;
  logic [1:0] q4_ph = 2'd0;
  logic [2:0] rc_ph = 3'd0;

  int n_total = 0;
  int n_pass  = 0;

  always #4 clk = ~clk;

  // ideal comparator on the modelled held input
  assign cmp_ge = (vin >= dac_code);

  always @(negedge clk) begin
    q4_ph     <= q4_ph + 2'd1;
    q4_strobe <= (q4_ph == 2'd3);
    rc_ph     <= (rc_ph == 3'd4) ? 3'd0 : rc_ph + 3'd1;
    rc_tick   <= (rc_ph == 3'd4);
  end

  sar_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .q4_strobe  (q4_strobe),
    .clk_sel    (clk_sel),
    .rc_tick    (rc_tick),
    .go_wr_en   (go_wr_en),
    .go_wr_data (go_wr_data),
    .flag_clr   (flag_clr),
    .cmp_ge     (cmp_ge),
    .dac_code   (dac_code),
    .sample_en  (sample_en),
    .result     (result),
    .go         (go),
    .done_flag  (done_flag)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
  endtask

  task automatic write_go(input logic val);
    go_wr_en   = 1'b1;
    go_wr_data = val;
    step();
    go_wr_en   = 1'b0;
    go_wr_data = 1'b0;
  endtask

  task automatic test_reset();
    chk(go == 1'b0,        "R1", "go after reset",        go, 0);
    chk(done_flag == 1'b0, "R1", "flag after reset",      done_flag, 0);
    chk(sample_en == 1'b1, "R1", "sample_en after reset", sample_en, 1);
    chk(result == 10'd0,   "R1", "result after reset",    result, 0);
    chk(dac_code == 10'd0, "R1", "dac_code after reset",  dac_code, 0);
  endtask

  // Full conversion; poke_busy repeats a GO=1 write mid-frame (R9)
  task automatic run_conv(input logic [1:0] sel, input logic [9:0] v, input bit poke_busy);
    logic [9:0] old_res;
    int q4_seen = 0;
    int len = 0;
    int rc_seen = 0;
    int first_trial = -1;
    bit last_q4 = 1'b0;
    bit res_held = 1'b1;
    int guard = 0;
    clear_flag();
    clk_sel = sel;
    vin = v;
    old_res = result;
    write_go(1'b1);
    chk(go == 1'b1, "R2", "go after write", go, 1);
    while (sample_en && guard < 100) begin
      if (q4_strobe) q4_seen++;
      last_q4 = q4_strobe;
      guard++;
      if (sample_en) step();
    end
    // the edge that started the frame used the q4 strobe now visible
    if (q4_strobe) q4_seen++;
    last_q4 = q4_strobe;
    chk(last_q4 == 1'b1, "R2", "start on q4 edge", last_q4, 1);
    if (sel == 2'd3)
      chk(q4_seen == 2, "R3", "q4 strobes before RC start", q4_seen, 2);
    else
      chk(q4_seen == 1, "R2", "q4 strobes before start", q4_seen, 1);
    chk(dac_code == 10'd0, "R5", "setup period code", dac_code, 0);
    len = 1;
    guard = 0;
    while (guard < 1000) begin
      if (poke_busy && len == 5) begin
        go_wr_en = 1'b1;
        go_wr_data = 1'b1;
      end else begin
        go_wr_en = 1'b0;
        go_wr_data = 1'b0;
      end
      step();
      guard++;
      if (sel == 2'd3 && rc_tick) rc_seen++;
      if (sample_en) break;
      len++;
      if (first_trial < 0 && dac_code != 10'd0) first_trial = int'(dac_code);
      if (result != old_res) res_held = 1'b0;
    end
    go_wr_en = 1'b0;
    go_wr_data = 1'b0;
    chk(first_trial == 'h200, "R5", "first trial code", first_trial, 'h200);
    chk(res_held, "R6", "result held during frame", int'(res_held), 1);
    if (sel == 2'd3)
      chk(rc_seen == 12, "R4", "rc periods in frame", rc_seen, 12);
    else
      chk(len == 12 * (sel == 2'd0 ? 2 : (sel == 2'd1 ? 8 : 32)),
          poke_busy ? "R9" : "R4", "hold window cycles", len,
          12 * (sel == 2'd0 ? 2 : (sel == 2'd1 ? 8 : 32)));
    chk(result == v,       poke_busy ? "R9" : "R5", "result code", result, v);
    chk(go == 1'b0,        "R6", "go at completion",   go, 0);
    chk(done_flag == 1'b1, "R6", "flag at completion", done_flag, 1);
  endtask

  task automatic test_sticky();
    repeat (20) step();
    chk(done_flag == 1'b1, "R8", "flag still set", done_flag, 1);
    clear_flag();
    chk(done_flag == 1'b0, "R8", "flag after clear", done_flag, 0);
  endtask

  task automatic test_abort();
    logic [9:0] old_res;
    int guard = 0;
    clear_flag();
    clk_sel = 2'd1;
    vin = 10'h0F0;
    old_res = result;
    write_go(1'b1);
    while (sample_en && guard < 100) begin
      step();
      guard++;
    end
    repeat (10) step();
    chk(sample_en == 1'b0, "R7", "in frame before abort", sample_en, 0);
    write_go(1'b0);
    chk(go == 1'b0,        "R7", "go after abort",        go, 0);
    chk(sample_en == 1'b1, "R7", "sampling after abort",  sample_en, 1);
    repeat (200) step();
    chk(done_flag == 1'b0, "R7", "no flag after abort",   done_flag, 0);
    chk(result == old_res, "R7", "result after abort",    result, old_res);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_total++;
    $display("FAIL watchdog: run did not end, got 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    test_reset();
    rst_n = 1'b1;
    step();
    run_conv(2'd0, 10'h2AA, 1'b0);
    test_sticky();
    run_conv(2'd1, 10'h155, 1'b0);
    run_conv(2'd2, 10'h3FF, 1'b0);
    run_conv(2'd0, 10'h000, 1'b0);
    run_conv(2'd3, 10'h200, 1'b0);
    run_conv(2'd0, 10'h1FF, 1'b1);
    test_abort();
    finish_run();
  end

endmodule